// File: doc/BRIEF.md
# Multiplexed ADC Readback Target

This block is the target side of a two-wire serial command port that sits in front of an eleven-channel monitoring converter. The host points it at a channel by writing an offset byte. That write also starts a conversion. While the conversion timer runs, any read addressed to the block is refused at the address phase. Once the timer expires, a read returns a 16-bit result word, high byte first. The word carries the converted channel number beside the 10-bit sample, so the host can confirm that the data belongs to the channel it asked for.

Line-level START/STOP detection and the pins are outside the block. It sees the bus as byte-level strobes: an address phase with its direction bit, a written data byte, a request for a read byte, and a stop. The analog converter is replaced by one sample bus per channel, and the block latches the selected sample when the conversion ends. Channels 0–5 are monitored rails, 6 is the supply, 7 is the high-voltage input, 8 is the internal temperature and 9–10 are auxiliary inputs.

Top module: `adc_rdbk_target`

## Requirements
- R1: After reset `conv_busy`, `ack_stb` and `rdat_stb` are low and the result word is 0x0000, so a first read returns bytes 0x00, 0x00.
- R2: A data byte written after a write-address phase selects channel `wdat[7:3]`. Bits `wdat[2:0]` are ignored. A channel from 0 to 10 starts a conversion at the clock edge that samples the byte.
- R3: A written byte whose channel field is above 10 starts nothing, leaves `conv_busy` low and leaves the result word unchanged.
- R4: `conv_busy` stays high for exactly `CLK_HZ*T/1e6` clock cycles after the start edge. T is 70 µs by default and 185 µs when `SLOW_CONV` is set.
- R5: A read-address phase that arrives while `conv_busy` is high is answered with ack_ok=0, and no read bytes are returned in that transaction.
- R6: Every address phase is answered one cycle later with `ack_stb`=1. A write address, or a read address while idle, gets ack_ok=1.
- R7: The result word is {0, channel[3:0], 0, sample[9:0]}: bit 15 and bit 10 are zero, bits 14:11 echo the channel and bits 9:0 hold that channel's sample as it stood at the end of the conversion.
- R8: Each read request in an acknowledged read transaction yields `rdat_stb` one cycle later. The bytes alternate high byte, low byte, high byte, starting with the high byte at each address phase.
- R9: A valid offset written while a conversion runs restarts the timer for the new channel, and the result then echoes the new channel.
- R10: A data byte written in a write transaction is acknowledged (`ack_stb`=1, `ack_ok`=1) one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_stb | input | 1 | Address phase (START plus address byte) |
| addr_rd | input | 1 | Direction of the address phase, 1 = read |
| wdat_stb | input | 1 | Host wrote a data byte |
| wdat | input | 8 | Written data byte (offset) |
| rreq_stb | input | 1 | Host clocks out one read byte |
| stop_stb | input | 1 | STOP seen, ends the transaction |
| samples | input | NCH*SAMPLE_W | Per-channel sample inputs, channel n at bits n*SAMPLE_W |
| ack_stb | output | 1 | Acknowledge slot valid |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK |
| rdat_stb | output | 1 | Read byte valid |
| rdat | output | 8 | Read byte |
| conv_busy | output | 1 | Conversion in progress |

## Verification
The checker watches every cycle for the following. An address phase always gets an acknowledge slot in the next cycle. A read address is NACKed whenever a conversion is running, and a write address is always ACKed. Read bytes appear only after a request. An out-of-range offset never raises busy from idle. The result word changes only when busy falls, and then it echoes the active channel. The exact length of the busy window, the byte order, the match between returned data and the injected per-channel sample, and the restart of a running conversion can only be shown by the bench's directed and random transactions, which compare against its own model of the word.

// File: rtl/adc_rdbk_pkg.sv
package adc_rdbk_pkg;
   localparam int BYTE_W = 8;
   localparam int CH_W   = 4;
   localparam int WORD_W = 16;
   localparam int OFS_SHIFT = 3;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WR   = 2'd1,
      PH_RD   = 2'd2
   } bus_phase_e;

   // conversion time in clock cycles from frequency and microseconds
   function automatic int conv_cycles(input int clk_hz, input int usec);
      return (clk_hz / 1000) * usec / 1000;
   endfunction
endpackage

// File: rtl/adc_offset_decode.sv
module adc_offset_decode
   import adc_rdbk_pkg::*;
#(
   parameter int NCH = 11
) (
   input  logic [BYTE_W-1:0] ofs_byte,
   output logic [CH_W-1:0]   ch_sel,
   output logic              ch_ok
);
   localparam int FLD_W = BYTE_W - OFS_SHIFT;

   logic [FLD_W-1:0]     fld;
   logic [OFS_SHIFT-1:0] unused_low;

   assign fld        = ofs_byte[BYTE_W-1:OFS_SHIFT];
   assign unused_low = ofs_byte[OFS_SHIFT-1:0];
   assign ch_sel     = fld[CH_W-1:0];
   assign ch_ok      = (int'(fld) < NCH);
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
   import adc_rdbk_pkg::*;
#(
   parameter int CYC = 8750
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [CH_W-1:0] ch_in,
   output logic            busy,
   output logic            done,
   output logic [CH_W-1:0] ch_act
);
   localparam int CNT_W = (CYC < 2) ? 1 : $clog2(CYC);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         ch_act <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         cnt    <= CNT_W'(CYC - 1);
         ch_act <= ch_in;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   assign done = busy && (cnt == '0) && !start;
endmodule

// File: rtl/adc_sample_mux.sv
module adc_sample_mux
   import adc_rdbk_pkg::*;
#(
   parameter int NCH      = 11,
   parameter int SAMPLE_W = 10
) (
   input  logic [NCH*SAMPLE_W-1:0] samples,
   input  logic [CH_W-1:0]         sel,
   output logic [SAMPLE_W-1:0]     smp
);
   localparam int SLOTS = 1 << CH_W;

   logic [SAMPLE_W-1:0] lane [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_lane
      if (g < NCH) begin : g_real
         assign lane[g] = samples[g*SAMPLE_W +: SAMPLE_W];
      end else begin : g_pad
         assign lane[g] = '0;
      end
   end

   assign smp = lane[sel];
endmodule

// File: rtl/adc_result_ser.sv
module adc_result_ser
   import adc_rdbk_pkg::*;
#(
   parameter int SAMPLE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CH_W-1:0]   ch,
   input  logic [SAMPLE_W-1:0] smp,
   input  logic              rewind,
   input  logic              rd_go,
   output logic [WORD_W-1:0] word,
   output logic              rd_stb,
   output logic [BYTE_W-1:0] rd_byte
);
   logic lo_next;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word <= '0;
      end else if (load) begin
         word <= {1'b0, ch, 1'b0, smp};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_next <= 1'b0;
         rd_stb  <= 1'b0;
         rd_byte <= '0;
      end else begin
         rd_stb <= rd_go;
         if (rewind) begin
            lo_next <= 1'b0;
         end else if (rd_go) begin
            rd_byte <= lo_next ? word[BYTE_W-1:0] : word[WORD_W-1:BYTE_W];
            lo_next <= !lo_next;
         end
      end
   end
endmodule

// File: rtl/adc_rdbk_target.sv
module adc_rdbk_target
   import adc_rdbk_pkg::*;
#(
   parameter int NCH       = 11,
   parameter int SAMPLE_W  = 10,
   parameter int CLK_HZ    = 125_000_000,
   parameter bit SLOW_CONV = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    addr_stb,
   input  logic                    addr_rd,
   input  logic                    wdat_stb,
   input  logic [7:0]              wdat,
   input  logic                    rreq_stb,
   input  logic                    stop_stb,
   input  logic [NCH*SAMPLE_W-1:0] samples,
   output logic                    ack_stb,
   output logic                    ack_ok,
   output logic                    rdat_stb,
   output logic [7:0]              rdat,
   output logic                    conv_busy
);
   localparam int CONV_US  = SLOW_CONV ? 185 : 70;
   localparam int CONV_CYC = conv_cycles(CLK_HZ, CONV_US);

   if (NCH < 1 || NCH > (1 << CH_W)) begin : g_bad_nch
      $error("NCH must fit the channel echo field");
   end
   if (SAMPLE_W + CH_W + 2 != WORD_W) begin : g_bad_w
      $error("sample, echo and pad bits must fill the result word");
   end
   if (CONV_CYC < 1) begin : g_bad_cyc
      $error("conversion time rounds to zero cycles");
   end

   bus_phase_e          phase;
   logic [CH_W-1:0]     dec_ch;
   logic                dec_ok;
   logic                conv_start;
   logic                conv_done;
   logic [CH_W-1:0]     act_ch;
   logic [SAMPLE_W-1:0] mux_smp;
   logic [WORD_W-1:0]   res_word;
   logic                rd_go;

   adc_offset_decode #(.NCH(NCH)) u_dec (
      .ofs_byte (wdat),
      .ch_sel   (dec_ch),
      .ch_ok    (dec_ok)
   );

   assign conv_start = wdat_stb && (phase == PH_WR) && dec_ok;

   adc_conv_timer #(.CYC(CONV_CYC)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (conv_start),
      .ch_in  (dec_ch),
      .busy   (conv_busy),
      .done   (conv_done),
      .ch_act (act_ch)
   );

   adc_sample_mux #(.NCH(NCH), .SAMPLE_W(SAMPLE_W)) u_mux (
      .samples (samples),
      .sel     (act_ch),
      .smp     (mux_smp)
   );

   assign rd_go = rreq_stb && (phase == PH_RD);

   adc_result_ser #(.SAMPLE_W(SAMPLE_W)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (conv_done),
      .ch      (act_ch),
      .smp     (mux_smp),
      .rewind  (addr_stb),
      .rd_go   (rd_go),
      .word    (res_word),
      .rd_stb  (rdat_stb),
      .rd_byte (rdat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         ack_stb <= 1'b0;
         ack_ok  <= 1'b0;
      end else begin
         ack_stb <= addr_stb || (wdat_stb && phase == PH_WR);
         ack_ok  <= addr_stb ? !(addr_rd && conv_busy) : 1'b1;
         if (addr_stb) begin
            if (!addr_rd)       phase <= PH_WR;
            else if (conv_busy) phase <= PH_IDLE;
            else                phase <= PH_RD;
         end else if (stop_stb) begin
            phase <= PH_IDLE;
         end
      end
   end
endmodule

// File: rtl/adc_rdbk_chk.sv
module adc_rdbk_chk #(
   parameter int NCH = 11
) (
   input logic        clk,
   input logic        rst_n,
   input logic        addr_stb,
   input logic        addr_rd,
   input logic        wdat_stb,
   input logic [7:0]  wdat,
   input logic        rreq_stb,
   input logic        ack_stb,
   input logic        ack_ok,
   input logic        rdat_stb,
   input logic        conv_busy,
   input logic [15:0] res_word,
   input logic [3:0]  act_ch
);
   a_r6_ack_slot: assert property (@(posedge clk) disable iff (!rst_n)
      addr_stb |=> ack_stb);

   a_r6_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_stb && !addr_rd) |=> ack_ok);

   a_r5_nack_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_stb && addr_rd && conv_busy) |=> (ack_stb && !ack_ok));

   a_r8_byte_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      rdat_stb |-> $past(rreq_stb));

   a_r3_no_start_range: assert property (@(posedge clk) disable iff (!rst_n)
      (wdat_stb && int'(wdat[7:3]) >= NCH && !conv_busy) |=> !conv_busy);

   a_r7_word_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(res_word) |-> $fell(conv_busy));

   a_r7_echo: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conv_busy) |-> (res_word[14:11] == act_ch && !res_word[15] && !res_word[10]));
endmodule

bind adc_rdbk_target adc_rdbk_chk #(.NCH(NCH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr_stb  (addr_stb),
   .addr_rd   (addr_rd),
   .wdat_stb  (wdat_stb),
   .wdat      (wdat),
   .rreq_stb  (rreq_stb),
   .ack_stb   (ack_stb),
   .ack_ok    (ack_ok),
   .rdat_stb  (rdat_stb),
   .conv_busy (conv_busy),
   .res_word  (res_word),
   .act_ch    (act_ch)
);

// File: tb/tb_adc_rdbk_target.sv
module tb_adc_rdbk_target;
   localparam int NCH  = 11;
   localparam int SW   = 10;
   localparam int CLKF = 2_000_000;
   localparam int CONV = (CLKF / 1000) * 70 / 1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic addr_stb = 0, addr_rd = 0, wdat_stb = 0, rreq_stb = 0, stop_stb = 0;
   logic [7:0] wdat = '0;
   logic [NCH*SW-1:0] samples = '0;
   logic ack_stb, ack_ok, rdat_stb, conv_busy;
   logic [7:0] rdat;

   int total = 0, bad = 0;
   logic [SW-1:0] smp [NCH];
   logic [15:0]   exp_word = 16'h0000;

   always #4 clk = ~clk;

   adc_rdbk_target #(.NCH(NCH), .SAMPLE_W(SW), .CLK_HZ(CLKF), .SLOW_CONV(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .addr_rd(addr_rd),
      .wdat_stb(wdat_stb), .wdat(wdat), .rreq_stb(rreq_stb), .stop_stb(stop_stb),
      .samples(samples), .ack_stb(ack_stb), .ack_ok(ack_ok), .rdat_stb(rdat_stb),
      .rdat(rdat), .conv_busy(conv_busy)
   );

   function automatic logic [15:0] mk_word(input int ch, input logic [SW-1:0] s);
      return {1'b0, 4'(ch), 1'b0, s};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic load_samples();
      for (int i = 0; i < NCH; i++) begin
         smp[i] = SW'($urandom);
         samples[i*SW +: SW] = smp[i];
      end
   endtask

   // write address plus one offset byte; returns at the negedge after the start edge
   task automatic write_ofs(input logic [7:0] b);
      @(negedge clk); addr_stb = 1; addr_rd = 0;
      @(negedge clk); addr_stb = 0;
      chk("R6 write addr ack", {ack_stb, ack_ok}, 2'b11);
      wdat_stb = 1; wdat = b;
      @(negedge clk); wdat_stb = 0;
      chk("R10 data ack", {ack_stb, ack_ok}, 2'b11);
   endtask

   task automatic stop_bus();
      stop_stb = 1;
      @(negedge clk); stop_stb = 0;
   endtask

   // read attempt; takes 2 negedges when refused
   task automatic read_word(input bit expect_ack, input string req);
      logic [7:0] b0, b1, b2;
      addr_stb = 1; addr_rd = 1;
      @(negedge clk); addr_stb = 0;
      chk({req, " read addr ack"}, {ack_stb, ack_ok}, {1'b1, expect_ack});
      rreq_stb = 1;
      @(negedge clk);
      if (!expect_ack) begin
         rreq_stb = 0;
         chk("R5 no data after NACK", rdat_stb, 1'b0);
         return;
      end
      chk("R8 byte strobe", rdat_stb, 1'b1); b0 = rdat;
      @(negedge clk); b1 = rdat;
      @(negedge clk); b2 = rdat; rreq_stb = 0;
      chk({req, " word"}, {b0, b1}, exp_word);
      chk("R8 third byte is high again", b2, exp_word[15:8]);
      stop_bus();
   endtask

   // full conversion on an in-range channel, with busy-window checks
   task automatic convert(input int ch);
      logic [7:0] ofs;
      ofs = {5'(ch), 3'($urandom)};
      write_ofs(ofs);                       // now 0 cycles after start edge
      chk("R2 busy after offset", conv_busy, 1'b1);
      @(negedge clk);                       // k=1
      read_word(1'b0, "R5");                // k=3
      stop_bus();                           // k=4
      repeat (CONV - 1 - 4) @(negedge clk);
      chk("R4 busy at last cycle", conv_busy, 1'b1);
      @(negedge clk);
      chk("R4 busy clears", conv_busy, 1'b0);
      exp_word = mk_word(ch, smp[ch]);
      @(negedge clk);
      read_word(1'b1, "R7");
   endtask

   task automatic bad_ofs(input int ch);
      write_ofs({5'(ch), 3'($urandom)});
      chk("R3 no busy for out-of-range", conv_busy, 1'b0);
      @(negedge clk);
      read_word(1'b1, "R3 result unchanged");
   endtask

   initial begin : watchdog
      repeat (150_000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      load_samples();
      repeat (4) @(negedge clk);
      chk("R1 busy in reset", conv_busy, 1'b0);
      chk("R1 no strobes in reset", {ack_stb, rdat_stb}, 2'b00);
      rst_n = 1;
      @(negedge clk);
      chk("R1 idle after reset", {conv_busy, ack_stb, rdat_stb}, 3'b000);
      read_word(1'b1, "R1");

      // every channel once, fresh samples each time
      for (int c = 0; c < NCH; c++) begin
         load_samples();
         convert(c);
      end

      // boundaries of the channel field
      bad_ofs(11);
      bad_ofs(31);
      load_samples();
      convert(10);
      convert(0);

      // restart while busy
      load_samples();
      write_ofs({5'd3, 3'd0});
      repeat (40) @(negedge clk);
      stop_bus();
      load_samples();
      write_ofs({5'd9, 3'd5});
      repeat (CONV - 1) @(negedge clk);
      chk("R9 busy extended by restart", conv_busy, 1'b1);
      @(negedge clk);
      chk("R9 busy ends after new window", conv_busy, 1'b0);
      exp_word = mk_word(9, smp[9]);
      @(negedge clk);
      read_word(1'b1, "R9");

      // random mix
      for (int n = 0; n < 20; n++) begin
         int ch;
         ch = int'($urandom_range(0, 15));
         load_samples();
         if (ch < NCH) convert(ch);
         else          bad_ofs(ch);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule